// File: doc/BRIEF.md
# Snoop Response Collector

On a snooping bus, memory must not answer a transaction before the caches have reported what they hold. This unit sits between the shared bus and the memory controller. It merges three per-cache snoop lines into wired-OR results: a copy is held somewhere, a modified copy is held somewhere, and some cache is still busy. It then decides when the snoop phase is over and tells memory whether to respond. If a modified copy exists, memory stays silent and a cache supplies the data. The merged "copy held" result goes back to the requester, so that it can pick a clean-exclusive or a shared fill state.

Two timing modes are chosen by a static mode input. In fixed mode, the lines are sampled a parameterised number of cycles after the request strobe. In variable mode, the unit waits until every cache has dropped its busy line, and a watchdog counter aborts the transaction when busy stays high too long. Only one transaction can be in flight at a time.

Top module: `snoop_collect`

## Requirements
- R1: During and after a synchronous active-high reset, all outputs are 0 until the first transaction completes.
- R2: In fixed mode (var_mode=0), the snoop lines are sampled in the cycle exactly SNOOP_LAT cycles after the cycle in which txn_valid was accepted, and snoop_done is high in the following cycle.
- R3: In variable mode (var_mode=1), the lines are sampled in the first cycle after acceptance in which no bit of snp_busy is 1, and snoop_done is high in the next cycle.
- R4: At the sampling cycle, res_shared becomes the OR of all snp_copy bits and res_dirty becomes the OR of all snp_mod bits.
- R5: mem_respond is high together with snoop_done exactly when res_dirty is 0. cache_supplies is high together with snoop_done exactly when res_dirty is 1. The two are never high together.
- R6: snoop_done, mem_respond and cache_supplies are single-cycle pulses.
- R7: res_shared and res_dirty hold their value from the snoop_done pulse until a new transaction is accepted, whatever the snoop lines do. In the cycle after acceptance they read 0.
- R8: A txn_valid arriving while a transaction is waiting is ignored: the timing and results of the current transaction are unchanged. proto_err pulses high for one cycle, in the cycle after the stray strobe.
- R9: In variable mode, if snp_busy still has a bit set in the cycle TIMEOUT_LIM cycles after acceptance, the transaction is aborted. timeout_err pulses for one cycle in the next cycle, no snoop_done, mem_respond or cache_supplies follows, and a new transaction may then be accepted.
- R10: In fixed mode, snp_busy has no effect on timing or results.
- R11: A txn_valid in the same cycle as a snoop_done pulse is accepted as a new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_valid | input | 1 | Bus transaction strobe |
| var_mode | input | 1 | 0 = fixed latency, 1 = wait on busy lines; static while a transaction is open |
| snp_copy | input | N_CACHE | Per-cache "holds a copy" line |
| snp_mod | input | N_CACHE | Per-cache "holds a modified copy" line |
| snp_busy | input | N_CACHE | Per-cache "snoop not finished" line |
| res_shared | output | 1 | Merged copy-held result, held until next transaction |
| res_dirty | output | 1 | Merged modified-copy result, held until next transaction |
| snoop_done | output | 1 | One-cycle pulse: snoop result known |
| mem_respond | output | 1 | One-cycle pulse: memory may answer |
| cache_supplies | output | 1 | One-cycle pulse: a cache provides the data |
| proto_err | output | 1 | One-cycle pulse: strobe arrived while busy |
| timeout_err | output | 1 | One-cycle pulse: variable-mode wait aborted |

## Verification
The assertions assume that var_mode does not change between acceptance and completion. Otherwise the wait counter could run past its limits, and the bound checks on it would not hold. They also assume the snoop lines are known values in each sampling cycle. The stimulus changes var_mode only while the unit is idle. It drives complemented "wrong" values on the lines in every non-sampling cycle, so a sample taken one cycle early or late shows up as a mismatch. Stray strobes are issued only while a transaction is already waiting.

// File: rtl/snp_pkg.sv
package snp_pkg;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_WAIT = 1'b1
    } win_state_e;

    typedef struct packed {
        logic shared;
        logic dirty;
    } snoop_res_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/snp_or_combine.sv
module snp_or_combine
    import snp_pkg::*;
#(
    parameter int N_CACHE = 4
) (
    input  logic [N_CACHE-1:0] copy_i,
    input  logic [N_CACHE-1:0] mod_i,
    input  logic [N_CACHE-1:0] busy_i,
    output snoop_res_t         res_o,
    output logic               any_busy_o
);

    logic [N_CACHE:0] c_chain;
    logic [N_CACHE:0] m_chain;
    logic [N_CACHE:0] b_chain;

    assign c_chain[0] = 1'b0;
    assign m_chain[0] = 1'b0;
    assign b_chain[0] = 1'b0;

    for (genvar g = 0; g < N_CACHE; g++) begin : g_or
        assign c_chain[g+1] = c_chain[g] | copy_i[g];
        assign m_chain[g+1] = m_chain[g] | mod_i[g];
        assign b_chain[g+1] = b_chain[g] | busy_i[g];
    end

    assign res_o.shared = c_chain[N_CACHE];
    assign res_o.dirty  = m_chain[N_CACHE];
    assign any_busy_o   = b_chain[N_CACHE];

endmodule

// File: rtl/snp_window.sv
module snp_window
    import snp_pkg::*;
#(
    parameter int SNOOP_LAT   = 3,
    parameter int TIMEOUT_LIM = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic txn_valid,
    input  logic var_mode,
    input  logic any_busy,
    output logic accept,
    output logic capture,
    output logic abort_now,
    output logic proto_err,
    output logic timeout_err
);

    localparam int MAXC = max_int(SNOOP_LAT, TIMEOUT_LIM);
    localparam int CW   = $clog2(MAXC + 2);
    localparam logic [CW-1:0] LAT_C = CW'(SNOOP_LAT);
    localparam logic [CW-1:0] TO_C  = CW'(TIMEOUT_LIM);
    localparam logic [CW-1:0] MAX_C = CW'(MAXC);

    win_state_e      st;
    logic [CW-1:0]   cnt;
    logic            in_wait;

    assign in_wait = (st == S_WAIT);

    always_comb begin
        accept    = !in_wait && txn_valid;
        capture   = in_wait && (var_mode ? !any_busy : (cnt == LAT_C));
        abort_now = in_wait && var_mode && any_busy && (cnt == TO_C);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= S_IDLE;
            cnt         <= '0;
            proto_err   <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            proto_err   <= in_wait && txn_valid;
            timeout_err <= abort_now;
            if (accept) begin
                st  <= S_WAIT;
                cnt <= CW'(1);
            end else if (capture || abort_now) begin
                st <= S_IDLE;
            end else if (in_wait) begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    AST_PROTO_CAUSE: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> ($past(txn_valid) && $past(in_wait)));           // R8
    AST_TIMEOUT_VAR: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> ($past(var_mode) && $past(any_busy)));         // R9
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        in_wait |-> (cnt != '0 && cnt <= MAX_C));                      // R2

endmodule

// File: rtl/snp_result.sv
module snp_result
    import snp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  logic       capture,
    input  snoop_res_t res_in,
    output snoop_res_t res_q,
    output logic       done,
    output logic       mem_go,
    output logic       supplies
);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q    <= '0;
            done     <= 1'b0;
            mem_go   <= 1'b0;
            supplies <= 1'b0;
        end else begin
            done     <= capture;
            mem_go   <= capture && !res_in.dirty;
            supplies <= capture && res_in.dirty;
            if (accept)
                res_q <= '0;
            else if (capture)
                res_q <= res_in;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                               // R6
    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_go && supplies));                                        // R5
    AST_MEM_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        (mem_go || supplies) |-> done);                                // R5
    AST_SUPPLY_DIRTY: assert property (@(posedge clk) disable iff (rst)
        done |-> (supplies == res_q.dirty));                           // R5
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(accept) && !$past(capture)) |-> $stable(res_q)); // R7

endmodule

// File: rtl/snoop_collect.sv
module snoop_collect
    import snp_pkg::*;
#(
    parameter int N_CACHE     = 4,
    parameter int SNOOP_LAT   = 3,
    parameter int TIMEOUT_LIM = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               txn_valid,
    input  logic               var_mode,
    input  logic [N_CACHE-1:0] snp_copy,
    input  logic [N_CACHE-1:0] snp_mod,
    input  logic [N_CACHE-1:0] snp_busy,
    output logic               res_shared,
    output logic               res_dirty,
    output logic               snoop_done,
    output logic               mem_respond,
    output logic               cache_supplies,
    output logic               proto_err,
    output logic               timeout_err
);

    snoop_res_t comb_res;
    snoop_res_t held_res;
    logic       any_busy;
    logic       accept;
    logic       capture;
    logic       abort_now;

    snp_or_combine #(.N_CACHE(N_CACHE)) u_or (
        .copy_i     (snp_copy),
        .mod_i      (snp_mod),
        .busy_i     (snp_busy),
        .res_o      (comb_res),
        .any_busy_o (any_busy)
    );

    snp_window #(.SNOOP_LAT(SNOOP_LAT), .TIMEOUT_LIM(TIMEOUT_LIM)) u_win (
        .clk         (clk),
        .rst         (rst),
        .txn_valid   (txn_valid),
        .var_mode    (var_mode),
        .any_busy    (any_busy),
        .accept      (accept),
        .capture     (capture),
        .abort_now   (abort_now),
        .proto_err   (proto_err),
        .timeout_err (timeout_err)
    );

    snp_result u_res (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .capture  (capture),
        .res_in   (comb_res),
        .res_q    (held_res),
        .done     (snoop_done),
        .mem_go   (mem_respond),
        .supplies (cache_supplies)
    );

    assign res_shared = held_res.shared;
    assign res_dirty  = held_res.dirty;

    AST_TIMEOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> !(snoop_done || mem_respond || cache_supplies)); // R9
    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(timeout_err && proto_err));                                    // R8

endmodule

// File: tb/sim_snoop_collect.sv
`timescale 1ns/1ps
module sim_snoop_collect;

    localparam int N = 3;
    localparam int L = 3;
    localparam int T = 6;
    localparam int WD_LIMIT = 20000;

    logic         clk = 1'b0;
    logic         rst;
    logic         txn_valid;
    logic         var_mode;
    logic [N-1:0] snp_copy, snp_mod, snp_busy;
    logic res_shared, res_dirty, snoop_done, mem_respond, cache_supplies;
    logic proto_err, timeout_err;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    snoop_collect #(.N_CACHE(N), .SNOOP_LAT(L), .TIMEOUT_LIM(T)) u0 (
        .clk(clk), .rst(rst), .txn_valid(txn_valid), .var_mode(var_mode),
        .snp_copy(snp_copy), .snp_mod(snp_mod), .snp_busy(snp_busy),
        .res_shared(res_shared), .res_dirty(res_dirty), .snoop_done(snoop_done),
        .mem_respond(mem_respond), .cache_supplies(cache_supplies),
        .proto_err(proto_err), .timeout_err(timeout_err)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    task automatic win();
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= WD_LIMIT) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    // Fixed-mode transaction; optional stray strobe in window 1 (R8)
    task automatic run_fixed(input logic [N-1:0] cp, input logic [N-1:0] md, input bit stray);
        var_mode  = 1'b0;
        txn_valid = 1'b1;
        snp_copy  = ~cp;
        snp_mod   = ~md;
        snp_busy  = '1;
        win();
        for (int j = 1; j <= L; j++) begin
            txn_valid = (stray && j == 1);
            if (j == 1) begin
                chk("R7", "res_shared cleared", res_shared, 0);
                chk("R7", "res_dirty cleared", res_dirty, 0);
            end
            if (stray && j == 2) chk("R8", "proto_err", proto_err, 1);
            chk("R2", "done early", snoop_done, 0);
            snp_copy = (j == L) ? cp : ~cp;
            snp_mod  = (j == L) ? md : ~md;
            snp_busy = '1;   // R10: busy ignored in fixed mode
            win();
        end
        txn_valid = 1'b0;
        snp_copy  = ~cp;
        snp_mod   = ~md;
        chk("R2", "done", snoop_done, 1);
        chk("R4", "res_shared", res_shared, |cp);
        chk("R4", "res_dirty", res_dirty, |md);
        chk("R5", "mem_respond", mem_respond, !(|md));
        chk("R5", "cache_supplies", cache_supplies, |md);
        chk("R10", "proto_err quiet", proto_err, 0);
    endtask

    // Variable-mode transaction with busy high for d cycles after acceptance
    task automatic run_var(input int d, input logic [N-1:0] cp, input logic [N-1:0] md);
        int last;
        var_mode  = 1'b1;
        txn_valid = 1'b1;
        snp_copy  = ~cp;
        snp_mod   = ~md;
        snp_busy  = '0;
        win();
        txn_valid = 1'b0;
        last = (d < T) ? d + 1 : T;
        for (int j = 1; j <= last; j++) begin
            chk("R3", "done early", snoop_done, 0);
            snp_busy = (j <= d) ? N'(1 << (j % N)) : '0;
            snp_copy = (j == d + 1) ? cp : ~cp;
            snp_mod  = (j == d + 1) ? md : ~md;
            win();
        end
        snp_busy = '0;
        snp_copy = ~cp;
        snp_mod  = ~md;
        if (d < T) begin
            chk("R3", "done", snoop_done, 1);
            chk("R4", "res_shared", res_shared, |cp);
            chk("R4", "res_dirty", res_dirty, |md);
            chk("R5", "mem_respond", mem_respond, !(|md));
            chk("R5", "cache_supplies", cache_supplies, |md);
            chk("R3", "timeout quiet", timeout_err, 0);
        end else begin
            chk("R9", "timeout_err", timeout_err, 1);
            chk("R9", "no done", snoop_done, 0);
            chk("R9", "no mem_respond", mem_respond, 0);
            chk("R9", "no supplies", cache_supplies, 0);
            win();
            chk("R9", "timeout pulse ends", timeout_err, 0);
        end
    endtask

    initial begin
        rst = 1'b1; txn_valid = 1'b0; var_mode = 1'b0;
        snp_copy = '1; snp_mod = '1; snp_busy = '1;
        repeat (3) win();
        rst = 1'b0;
        chk("R1", "res_shared", res_shared, 0);
        chk("R1", "res_dirty", res_dirty, 0);
        chk("R1", "snoop_done", snoop_done, 0);
        chk("R1", "mem_respond", mem_respond, 0);
        chk("R1", "cache_supplies", cache_supplies, 0);
        chk("R1", "errors", {proto_err, timeout_err}, 0);
        win();

        // Fixed mode: every copy/mod pattern, back-to-back (R11 at each done)
        for (int c = 0; c < (1 << N); c++)
            for (int m = 0; m < (1 << N); m++)
                run_fixed(N'(c), N'(m), 1'b0);

        // Hold after done (R6, R7)
        win();
        for (int k = 0; k < 4; k++) begin
            snp_copy = N'(k); snp_mod = N'(k + 3); snp_busy = N'(k);
            chk("R6", "done pulse", snoop_done, 0);
            chk("R6", "mem pulse", mem_respond | cache_supplies, 0);
            chk("R7", "res_shared hold", res_shared, 1);
            chk("R7", "res_dirty hold", res_dirty, 1);
            win();
        end

        // Stray strobes while waiting (R8)
        run_fixed(3'b010, 3'b000, 1'b1);
        run_fixed(3'b000, 3'b100, 1'b1);
        win();
        chk("R8", "proto pulse ends", proto_err, 0);

        // Variable mode: busy lengths across and beyond the limit (R3, R9)
        for (int d = 0; d <= T + 1; d++)
            run_var(d, N'(d % 8), N'((d * 3) % 8));
        run_var(2, 3'b111, 3'b000);
        win();
        run_fixed(3'b001, 3'b000, 1'b0);   // mode change while idle

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule